// File: doc/BRIEF.md
# Programmable Sinc Decimation Filter

This block turns the 1-bit output of a sigma-delta modulator into signed 24-bit conversion words. It is a cascaded integrator-comb decimator. The decimation ratio is 1024 times a 10-bit rate code, so the word rate is the modulator sample rate divided by 1024 × code. A select input chooses a third-order or a fourth-order sinc response. Integrators and combs run in wrapping two's-complement arithmetic. They are wide enough for the full growth of the largest ratio at fourth order.

A channel-change pulse clears all filter state. The filter then holds back its output until the response has fully settled, which takes as many decimation periods as the filter order. After that, words follow once per period. With zero latency enabled, the filter restarts from a cleared state after each word. Every word is then a fully settled result, and words arrive once every order-many periods.

The rate code, order select and zero-latency enable are captured when a channel change occurs and on the first cycle after reset. At any other time they are ignored.

Top module: `sinc_decim`

## Requirements
- R1: After settling, `out_valid` pulses once for every 1024 × FS samples accepted with `mod_en` high. The pulse comes in the cycle after the edge that accepted the last sample of the period.
- R2: A captured rate code of 0 behaves exactly as a code of 1.
- R3: A captured `ord3_sel` of 1 gives third order (N=3) and 0 gives fourth order (N=4). Let R = 1024 × FS. The wide result y is the sum of h[j]·x[n−1−j], where h holds the coefficients of (1+z⁻¹+…+z⁻⁽ᴿ⁻¹⁾)^N and n is the number of samples accepted since the last clear. Samples before the clear count as zero.
- R4: A modulator bit of 1 enters the filter as +1, and a bit of 0 enters as −1.
- R5: A `chan_chg` pulse clears all state and drops any sample offered in the same cycle. No word follows until the end of the N-th period after the clear.
- R6: With zero latency captured as 1, the filter clears itself after each word. Words come only every N periods, and each one is computed from cleared state.
- R7: `out_word` equals y shifted arithmetically right by N·(10+L) − 22, where L is the bit length of FS−1. This keeps full scale within ±2^22.
- R8: `out_valid` lasts one cycle, and `out_word` holds its value between pulses.
- R9: Changes on `rate_code`, `ord3_sel` and `zl_en` in cycles without a channel change have no effect.
- R10: After reset, `out_valid` is 0 and `out_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Modulator sample enable |
| mod_bit | input | 1 | Modulator bitstream sample |
| rate_code | input | 10 | Decimation code FS |
| ord3_sel | input | 1 | 1 = third order, 0 = fourth order |
| zl_en | input | 1 | Zero-latency enable |
| chan_chg | input | 1 | Channel-change pulse |
| out_word | output | 24 | Signed conversion result |
| out_valid | output | 1 | One-cycle result strobe |

## Verification
The checker tests four properties on every cycle:
- the strobe lasts exactly one cycle;
- the word holds between strobes;
- the word stays within ±2^22;
- no strobe appears before at least 3072 samples have been accepted since a channel change.

The numerical result is shown only by bench scenarios, which compare each word against a direct convolution with sinc coefficients. The same holds for the exact settling period for each order, for zero-latency spacing, for a code of 0, for the sample dropped on a channel change, and for configuration inputs being ignored mid-run.

// File: rtl/sinc_dec_pkg.sv
package sinc_dec_pkg;
  localparam int RATE_BITS = 10;
  localparam int BASE_LOG2 = 10;
  localparam int MAX_ORDER = 4;
  localparam int ACC_W     = MAX_ORDER * (RATE_BITS + BASE_LOG2) + 1;
  localparam int OUT_W     = 24;
  localparam int HEAD      = OUT_W - 2;
  localparam int CNT_W     = RATE_BITS + BASE_LOG2;
  localparam int SH_W      = 7;
  localparam int PER_W     = 3;

  typedef struct packed {
    logic [RATE_BITS-1:0] fs;
    logic                 ord3;
    logic                 zl;
  } cfg_t;

  // right shift that brings full scale R^N down to 2^HEAD
  function automatic logic [SH_W-1:0] shift_for(logic [RATE_BITS-1:0] fs, logic ord3);
    logic [RATE_BITS-1:0] fm1;
    int l;
    int n;
    fm1 = fs - 1'b1;
    l = 0;
    for (int i = 0; i < RATE_BITS; i++)
      if (fm1[i]) l = i + 1;
    n = ord3 ? 3 : 4;
    return SH_W'(n * (BASE_LOG2 + l) - HEAD);
  endfunction
endpackage

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain
  import sinc_dec_pkg::*;
#(
  parameter int W      = ACC_W,
  parameter int STAGES = MAX_ORDER
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         clr,
  input  logic                         smp_en,
  input  logic                         x_bit,
  output logic [STAGES-1:0][W-1:0]     sum_o
);
  logic [W-1:0]                xin;
  logic [STAGES-1:0][W-1:0]    acc_q;
  logic [STAGES-1:0][W-1:0]    acc_d;

  assign xin = x_bit ? W'(1) : {W{1'b1}};

  // sums include the current sample so the chain adds no delay
  always_comb begin
    logic [W-1:0] run;
    run = xin;
    for (int i = 0; i < STAGES; i++) begin
      run      = acc_q[i] + run;
      sum_o[i] = run;
      if (clr)         acc_d[i] = '0;
      else if (smp_en) acc_d[i] = run;
      else             acc_d[i] = acc_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/sinc_comb_chain.sv
module sinc_comb_chain
  import sinc_dec_pkg::*;
#(
  parameter int W      = ACC_W,
  parameter int STAGES = MAX_ORDER
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  input  logic          ord3,
  input  logic [W-1:0]  v_in,
  output logic [W-1:0]  y_out
);
  logic [STAGES-1:0][W-1:0] dly_q;
  logic [STAGES-1:0][W-1:0] dly_d;
  logic [STAGES-1:0][W-1:0] diff;

  always_comb begin
    logic [W-1:0] run;
    run = v_in;
    for (int i = 0; i < STAGES; i++) begin
      if (clr)       dly_d[i] = '0;
      else if (tick) dly_d[i] = run;
      else           dly_d[i] = dly_q[i];
      run     = run - dly_q[i];
      diff[i] = run;
    end
  end

  generate
    if (STAGES >= 4) begin : g_sel
      assign y_out = ord3 ? diff[2] : diff[3];
    end else begin : g_fixed
      assign y_out = diff[STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly_q <= '0;
    else        dly_q <= dly_d;
  end
endmodule

// File: rtl/sinc_dec_ctrl.sv
module sinc_dec_ctrl
  import sinc_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mod_en,
  input  logic                 chg,
  input  logic [RATE_BITS-1:0] fs_in,
  input  logic                 ord3_in,
  input  logic                 zl_in,
  output logic                 smp_en,
  output logic                 tick,
  output logic                 emit,
  output logic                 clr,
  output cfg_t                 cfg,
  output logic [SH_W-1:0]      shamt
);
  logic              ld_pend_q, ld_pend_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [PER_W-1:0]  per_q, per_d;
  cfg_t              cfg_q, cfg_d;
  logic [SH_W-1:0]   sh_q, sh_d;
  logic              load;
  logic [CNT_W-1:0]  lim;
  logic [PER_W-1:0]  settle_pt;

  assign cfg   = cfg_q;
  assign shamt = sh_q;

  always_comb begin
    load      = ld_pend_q | chg;
    smp_en    = mod_en & ~load;
    lim       = {cfg_q.fs, {BASE_LOG2{1'b0}}} - 1'b1;
    tick      = smp_en & (cnt_q == lim);
    settle_pt = cfg_q.ord3 ? PER_W'(2) : PER_W'(3);
    emit      = tick & (per_q >= settle_pt);
    clr       = load | (emit & cfg_q.zl);

    ld_pend_d = 1'b0;

    if (clr | tick)  cnt_d = '0;
    else if (smp_en) cnt_d = cnt_q + 1'b1;
    else             cnt_d = cnt_q;

    if (clr)                             per_d = '0;
    else if (tick && per_q < settle_pt)  per_d = per_q + 1'b1;
    else                                 per_d = per_q;

    cfg_d = cfg_q;
    sh_d  = sh_q;
    if (load) begin
      cfg_d.fs   = (fs_in == '0) ? RATE_BITS'(1) : fs_in;
      cfg_d.ord3 = ord3_in;
      cfg_d.zl   = zl_in;
      sh_d       = shift_for(cfg_d.fs, ord3_in);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_pend_q <= 1'b1;
      cnt_q     <= '0;
      per_q     <= '0;
      cfg_q     <= '{fs: RATE_BITS'(1), ord3: 1'b0, zl: 1'b0};
      sh_q      <= '0;
    end else begin
      ld_pend_q <= ld_pend_d;
      cnt_q     <= cnt_d;
      per_q     <= per_d;
      cfg_q     <= cfg_d;
      sh_q      <= sh_d;
    end
  end
endmodule

// File: rtl/sinc_decim.sv
module sinc_decim
  import sinc_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mod_en,
  input  logic                 mod_bit,
  input  logic [RATE_BITS-1:0] rate_code,
  input  logic                 ord3_sel,
  input  logic                 zl_en,
  input  logic                 chan_chg,
  output logic [OUT_W-1:0]     out_word,
  output logic                 out_valid
);
  logic [1:0]                    rst_sync;
  logic                          rst_int_n;
  logic                          smp_en, tick, emit, clr;
  cfg_t                          cfg;
  logic [SH_W-1:0]               shamt;
  logic [MAX_ORDER-1:0][ACC_W-1:0] isum;
  logic [ACC_W-1:0]              comb_in, y;
  logic signed [ACC_W-1:0]       scaled;
  logic [OUT_W-1:0]              word_q, word_d;
  logic                          vld_q, vld_d;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  sinc_dec_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_int_n), .mod_en(mod_en), .chg(chan_chg),
    .fs_in(rate_code), .ord3_in(ord3_sel), .zl_in(zl_en),
    .smp_en(smp_en), .tick(tick), .emit(emit), .clr(clr),
    .cfg(cfg), .shamt(shamt)
  );

  sinc_integ_chain #(.W(ACC_W), .STAGES(MAX_ORDER)) u_integ (
    .clk(clk), .rst_n(rst_int_n), .clr(clr), .smp_en(smp_en),
    .x_bit(mod_bit), .sum_o(isum)
  );

  assign comb_in = cfg.ord3 ? isum[2] : isum[MAX_ORDER-1];

  sinc_comb_chain #(.W(ACC_W), .STAGES(MAX_ORDER)) u_comb (
    .clk(clk), .rst_n(rst_int_n), .clr(clr), .tick(tick),
    .ord3(cfg.ord3), .v_in(comb_in), .y_out(y)
  );

  always_comb begin
    scaled = $signed(y) >>> shamt;
    vld_d  = emit;
    word_d = emit ? scaled[OUT_W-1:0] : word_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  assign out_word  = word_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/sinc_decim_chk.sv
module sinc_decim_chk
  import sinc_dec_pkg::*;
#(
  parameter int MIN_SETTLE = 3 << BASE_LOG2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mod_en,
  input logic             chan_chg,
  input logic [OUT_W-1:0] out_word,
  input logic             out_valid
);
  localparam int SC_W = $clog2(MIN_SETTLE + 1);
  localparam logic signed [OUT_W-1:0] FS_POS = OUT_W'(1) <<< HEAD;

  logic [SC_W-1:0] since_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_chg <= '0;
    else if (chan_chg)                   since_chg <= '0;
    else if (mod_en && since_chg < SC_W'(MIN_SETTLE)) since_chg <= since_chg + 1'b1;
  end

  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_word));

  // R7
  word_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($signed(out_word) <= FS_POS && $signed(out_word) >= -FS_POS));

  // R5
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> since_chg >= SC_W'(MIN_SETTLE));
endmodule

bind sinc_decim sinc_decim_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .chan_chg(chan_chg),
  .out_word(out_word), .out_valid(out_valid)
);

// File: tb/sinc_decim_bench.sv
module sinc_decim_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 195000;

  logic        clk;
  logic        rst_n;
  logic        mod_en;
  logic        mod_bit;
  logic [9:0]  rate_code;
  logic        ord3_sel;
  logic        zl_en;
  logic        chan_chg;
  logic [23:0] out_word;
  logic        out_valid;

  int checks;
  int errors;
  int cyc;
  bit done;

  // reference model state
  bit      m_pend;
  int      m_r, m_n, m_cnt, m_per, m_sh;
  bit      m_zl;
  bit      exp_v;
  longint  exp_w;
  string   m_tag;
  longint  hw[];
  longint  cur[];
  longint  nxt[];
  longint  pre[];
  int      hist[$];

  sinc_decim u_sinc_decim (
    .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .mod_bit(mod_bit),
    .rate_code(rate_code), .ord3_sel(ord3_sel), .zl_en(zl_en),
    .chan_chg(chan_chg), .out_word(out_word), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !done) begin
      errors = errors + 1;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer than %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // sinc^N coefficients by repeated box convolution via prefix sums (R3)
  function automatic void build_h(int r, int n);
    int len;
    len = r;
    cur = new[r];
    foreach (cur[i]) cur[i] = 1;
    for (int k = 2; k <= n; k++) begin
      pre = new[len + 1];
      pre[0] = 0;
      for (int i = 0; i < len; i++) pre[i+1] = pre[i] + cur[i];
      nxt = new[len + r - 1];
      for (int j = 0; j < len + r - 1; j++) begin
        int lo, hi;
        lo = (j - r + 1 < 0) ? 0 : j - r + 1;
        hi = (j > len - 1) ? len - 1 : j;
        nxt[j] = pre[hi+1] - pre[lo];
      end
      cur = nxt;
      len = len + r - 1;
    end
    hw = cur;
  endfunction

  function automatic int shift_of(int fs, int n);
    int l;
    l = 0;
    for (int i = 0; i < 10; i++) if (((fs - 1) >> i) & 1) l = i + 1;
    return n * (10 + l) - 22;
  endfunction

  function automatic longint conv_now();
    longint y;
    int n;
    y = 0;
    n = hist.size();
    for (int j = 0; j < hw.size() && j < n; j++) y += hw[j] * longint'(hist[n-1-j]);
    return y;
  endfunction

  task automatic check_out();
    longint act;
    act = longint'($signed(out_word));
    if (out_valid || exp_v) begin
      checks++;
      if (out_valid !== exp_v) begin
        errors++;
        $display("FAIL %s R1 R5: out_valid actual %0b expected %0b", m_tag, out_valid, exp_v);
      end else if (act != exp_w) begin
        errors++;
        $display("FAIL %s R3 R7: out_word actual %0d expected %0d", m_tag, act, exp_w);
      end
    end
  endtask

  // one cycle: check previous result, drive, advance model
  task automatic step(bit en, bit b, bit chg, logic [9:0] fs, bit o3, bit zl);
    check_out();
    mod_en = en; mod_bit = b; chan_chg = chg;
    rate_code = fs; ord3_sel = o3; zl_en = zl;
    exp_v = 1'b0;
    if (m_pend || chg) begin
      m_pend = 1'b0;
      m_r  = ((fs == 0) ? 1 : int'(fs)) * 1024;
      m_n  = o3 ? 3 : 4;
      m_zl = zl;
      m_sh = shift_of(m_r / 1024, m_n);
      build_h(m_r, m_n);
      hist.delete();
      m_cnt = 0;
      m_per = 0;
    end else if (en) begin
      hist.push_back(b ? 1 : -1);                 // R4
      if (m_cnt == m_r - 1) begin
        m_cnt = 0;
        if (m_per >= m_n - 1) begin
          exp_v = 1'b1;
          exp_w = conv_now() >>> m_sh;
          if (m_zl) begin                          // R6
            hist.delete();
            m_per = 0;
          end
        end else m_per++;
      end else m_cnt++;
    end
    @(negedge clk);
  endtask

  // scenario: channel change with a sample offered (R5), then random run;
  // config inputs randomised afterwards (R9)
  task automatic run(string tag, int fs, bit o3, bit zl, int dens, int nsamp);
    int got;
    m_tag = tag;
    step(1'b1, 1'b1, 1'b1, 10'(fs), o3, zl);
    got = 0;
    while (got < nsamp) begin
      bit en;
      bit b;
      en = ($urandom % 8) != 0;
      b  = ($urandom % 100) < dens;
      step(en, b, 1'b0, 10'($urandom), 1'($urandom), 1'($urandom));
      if (en) got++;
    end
    step(1'b0, 1'b0, 1'b0, 10'($urandom), 1'($urandom), 1'($urandom));
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    checks = 0; errors = 0; cyc = 0; done = 0;
    exp_v = 0; exp_w = 0; m_pend = 1; m_tag = "R10";
    mod_en = 0; mod_bit = 0; chan_chg = 0; rate_code = 10'd1; ord3_sel = 0; zl_en = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 1'b0, 10'd1, 1'b0, 1'b0);

    // R10 reset state
    checks++;
    if (out_valid !== 1'b0) begin
      errors++;
      $display("FAIL R10: out_valid actual %0b expected 0", out_valid);
    end
    checks++;
    if (out_word !== 24'd0) begin
      errors++;
      $display("FAIL R10: out_word actual %0d expected 0", out_word);
    end

    run("R1 R3 third order random",      1, 1'b1, 1'b0, 50, 6*1024 + 10);
    run("R2 R4 code zero all ones",      0, 1'b0, 1'b0, 100, 6*1024 + 10);
    run("R6 zero latency third order",   2, 1'b1, 1'b1, 70, 7*2048 + 10);
    run("R9 fourth order random cfg",    3, 1'b0, 1'b0, 30, 5*3072 + 10);
    run("R4 R6 zero latency all zeros",  1, 1'b0, 1'b1, 0, 9*1024 + 10);
    run("R5 early change",               1, 1'b1, 1'b0, 60, 1500);
    run("R5 after change",               1, 1'b1, 1'b0, 60, 5*1024 + 10);
    run("R7 code five third order",      5, 1'b1, 1'b0, 95, 3*5120 + 10);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule